// File: doc/BRIEF.md
# Blanking Window with Edge Ramp

This block opens and closes the active-video window on every line. Instead of switching pixel data on and off abruptly, it moves a per-pixel gain factor in equal steps between zero and unity, and it multiplies each incoming pixel by that gain. A pixel counter restarts on each line-start strobe. Two programmable 11-bit positions set where the window opens and where it closes.

A mode input selects one of two uses.

- **Drive mode** (`mode_gate` = 0): the internal window goes out on `win_out`, and `win_oe` is high so that a pad can drive it.
- **Gate mode** (`mode_gate` = 1): the pad is released, and an external level `win_ext_in` qualifies the internal window. A high external level lets the internal window act. A low external level forces blanking. The external level can never open a window that the internal timing has closed.

Transitions caused by the external level use the same gain steps as the internal window.

With the default parameters, the ramp takes four pixels. The gain is unsigned with 8 fraction bits, so unity is 256 and one step is 64. Every output is registered. The result for a pixel presented in cycle n appears after the clock edge that ends cycle n.

Top module: `blank_window_ramp`

## Requirements
- R1: While reset is asserted and after it is released, `gain_out`, `pix_out`, `win_out` and `win_oe` are 0 until the first clock edge outside reset. Before the first line-start strobe, the pixel counter sits at its maximum value 2047. No window can open at that position.
- R2: In drive mode, `win_oe` is 1. `win_out` is high for the pixels with index p where `start_pos` <= p < `end_pos`, and low elsewhere. The pixel presented with `line_start` high has index 0, and each later pixel adds one.
- R3: `gain_out` equals level × 256 / 4, where the level is an integer from 0 to 4. The only legal values are 0, 64, 128, 192 and 256.
- R4: `gain_out` changes by at most one step (64) from one pixel to the next. It never jumps.
- R5: With a window at least 7 pixels long, the up-ramp works as follows. Pixel `start_pos` gets gain 64, the gain rises by 64 per pixel, and pixel `start_pos`+3 gets 256. For the down-ramp, pixel `end_pos`-3 gets 192, pixel `end_pos`-1 gets 64 (the last pixel with nonzero gain), and pixel `end_pos` gets 0.
- R6: In gate mode, `win_oe` and `win_out` are 0. While `win_ext_in` is high, the gain follows exactly the sequence that drive mode would produce. While `win_ext_in` is low, the gain steps down toward 0 and never rises.
- R7: If `win_ext_in` falls part-way through an up-ramp, the gain reverses from its current value in steps of 64. When the level returns high, the gain climbs again from its current value.
- R8: `pix_out` equals floor(`pix_in` × `gain_out` / 256) for the same pixel. A gain of 0 gives 0, and a gain of 256 returns the input unchanged.
- R9: The pixel counter saturates at 2047. A line longer than 2048 pixels keeps index 2047, and the window closes as though the line had ended there.
- R10: A line-start strobe in the middle of a line restarts the index at 0 for that pixel. The window then follows the new count, and the gain keeps ramping from its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one pixel per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | High on the first pixel of a line |
| mode_gate | input | 1 | 0 = drive window out, 1 = gate by external level |
| start_pos | input | 11 | Pixel index at which the window opens |
| end_pos | input | 11 | Pixel index at which the window has closed |
| win_ext_in | input | 1 | External window level, used in gate mode |
| pix_in | input | 10 | Pixel data sample |
| win_out | output | 1 | Window level for the pad (drive mode) |
| win_oe | output | 1 | Pad drive enable, high in drive mode |
| gain_out | output | 9 | Applied gain, unity = 256 |
| pix_out | output | 10 | Pixel data scaled by the gain |

## Verification
The checker takes for granted that `mode_gate` and `win_ext_in` are synchronous to the pixel clock and are sampled with the pixel they belong to. It also assumes that `start_pos` and `end_pos` change only between lines, so that a rising gain always falls inside the driven window. The stimulus changes the positions and the mode only at line boundaries. It toggles the external level on chosen pixels, including pixels in the middle of a ramp. Short windows that never reach unity are also driven; they exercise the reversal path without breaking any property.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

   // Pin role chosen by the mode input.
   typedef enum logic {
      BWR_DRIVE = 1'b0,
      BWR_GATE  = 1'b1
   } bwr_mode_e;

   // Gain for a ramp level: level / ramp_len, as a fixed-point value with frac_w fraction bits.
   function automatic int unsigned bwr_level_gain(input int unsigned lvl,
                                                  input int unsigned ramp_len,
                                                  input int unsigned frac_w);
      return (lvl << frac_w) / ramp_len;
   endfunction

endpackage

// File: rtl/bwr_pos_counter.sv
module bwr_pos_counter #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   output logic [CNT_W-1:0] pos
);

   localparam logic [CNT_W-1:0] POS_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   // Index of the pixel presented in this cycle: zero on a line start, otherwise one past the last index, held at the top value.
   always_comb begin
      if (line_start)
         pos = '0;
      else if (cnt_q == POS_MAX)
         pos = POS_MAX;
      else
         pos = cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= POS_MAX;
      else
         cnt_q <= pos;
   end

endmodule

// File: rtl/bwr_window_decode.sv
module bwr_window_decode #(
   parameter int CNT_W    = 11,
   parameter int RAMP_LEN = 4
) (
   input  logic             [CNT_W-1:0] pos,
   input  logic             [CNT_W-1:0] start_pos,
   input  logic             [CNT_W-1:0] end_pos,
   input  bwr_pkg::bwr_mode_e           mode,
   input  logic                         ext_level,
   output logic                         pin_win,
   output logic                         target
);

   localparam int EXT_W = CNT_W + 2;

   logic [EXT_W-1:0] lead_pos;
   logic [EXT_W-1:0] end_ext;
   logic             early_close;
   logic             gate_ok;

   // The internal target closes RAMP_LEN-1 pixels early, so the down-ramp ends on the last pixel inside the pin window.
   assign lead_pos    = EXT_W'(pos) + EXT_W'(RAMP_LEN - 1);
   assign end_ext     = EXT_W'(end_pos);
   assign early_close = (lead_pos >= end_ext);

   assign pin_win = (pos >= start_pos) && (pos < end_pos);
   assign gate_ok = (mode == bwr_pkg::BWR_GATE) ? ext_level : 1'b1;
   assign target  = pin_win && !early_close && gate_ok;

endmodule

// File: rtl/bwr_ramp_level.sv
module bwr_ramp_level #(
   parameter int RAMP_LEN = 4,
   parameter int LVL_W    = $clog2(RAMP_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             target,
   output logic [LVL_W-1:0] lvl_d
);

   localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(RAMP_LEN);

   logic [LVL_W-1:0] lvl_q;

   // Move one step toward the target from wherever the level stands; a reversal therefore never jumps.
   always_comb begin
      lvl_d = lvl_q;
      if (target && (lvl_q != LVL_TOP))
         lvl_d = lvl_q + 1'b1;
      else if (!target && (lvl_q != '0))
         lvl_d = lvl_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         lvl_q <= '0;
      else
         lvl_q <= lvl_d;
   end

endmodule

// File: rtl/bwr_pixel_scale.sv
module bwr_pixel_scale #(
   parameter int PIX_W  = 10,
   parameter int FRAC_W = 8,
   parameter bit ROUND  = 1'b0,
   parameter int GAIN_W = FRAC_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  pix_in,
   input  logic [GAIN_W-1:0] gain,
   output logic [PIX_W-1:0]  pix_out
);

   localparam int PROD_W = PIX_W + GAIN_W;

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] biased;
   logic [PROD_W-1:0] shifted;
   logic [PIX_W-1:0]  pix_d;

   assign prod = PROD_W'(pix_in) * PROD_W'(gain);

   generate
      if (ROUND) begin : g_round
         assign biased = prod + PROD_W'(1 << (FRAC_W - 1));
      end else begin : g_trunc
         assign biased = prod;
      end
   endgenerate

   assign shifted = biased >> FRAC_W;
   assign pix_d   = PIX_W'(shifted);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pix_out <= '0;
      else
         pix_out <= pix_d;
   end

endmodule

// File: rtl/blank_window_ramp.sv
module blank_window_ramp #(
   parameter int CNT_W    = 11,
   parameter int PIX_W    = 10,
   parameter int FRAC_W   = 8,
   parameter int RAMP_LEN = 4,
   parameter bit ROUND    = 1'b0,
   localparam int GAIN_W  = FRAC_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              mode_gate,
   input  logic [CNT_W-1:0]  start_pos,
   input  logic [CNT_W-1:0]  end_pos,
   input  logic              win_ext_in,
   input  logic [PIX_W-1:0]  pix_in,
   output logic              win_out,
   output logic              win_oe,
   output logic [GAIN_W-1:0] gain_out,
   output logic [PIX_W-1:0]  pix_out
);

   localparam int LVL_W = $clog2(RAMP_LEN + 1);

   // Elaboration-time parameter checks
   generate
      if (RAMP_LEN < 2 || (RAMP_LEN & (RAMP_LEN - 1)) != 0) begin : g_bad_ramp
         $error("RAMP_LEN must be a power of two of at least 2");
      end
      if (FRAC_W < $clog2(RAMP_LEN)) begin : g_bad_frac
         $error("FRAC_W too narrow for exact ramp steps");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (PIX_W < 1) begin : g_bad_pix
         $error("PIX_W must be positive");
      end
   endgenerate

   bwr_pkg::bwr_mode_e mode;
   logic [CNT_W-1:0]   pos;
   logic               pin_win;
   logic               target;
   logic [LVL_W-1:0]   lvl_d;
   logic [GAIN_W-1:0]  gain_lut [RAMP_LEN+1];
   logic [GAIN_W-1:0]  gain_d;

   assign mode = bwr_pkg::bwr_mode_e'(mode_gate);

   bwr_pos_counter #(.CNT_W(CNT_W)) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .pos        (pos)
   );

   bwr_window_decode #(.CNT_W(CNT_W), .RAMP_LEN(RAMP_LEN)) u_win (
      .pos       (pos),
      .start_pos (start_pos),
      .end_pos   (end_pos),
      .mode      (mode),
      .ext_level (win_ext_in),
      .pin_win   (pin_win),
      .target    (target)
   );

   bwr_ramp_level #(.RAMP_LEN(RAMP_LEN), .LVL_W(LVL_W)) u_lvl (
      .clk    (clk),
      .rst_n  (rst_n),
      .target (target),
      .lvl_d  (lvl_d)
   );

   // Gain table, one constant per ramp level
   generate
      for (genvar g = 0; g <= RAMP_LEN; g++) begin : g_lut
         assign gain_lut[g] = GAIN_W'(bwr_pkg::bwr_level_gain(g, RAMP_LEN, FRAC_W));
      end
   endgenerate

   assign gain_d = gain_lut[lvl_d];

   bwr_pixel_scale #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .ROUND(ROUND), .GAIN_W(GAIN_W)) u_scale (
      .clk     (clk),
      .rst_n   (rst_n),
      .pix_in  (pix_in),
      .gain    (gain_d),
      .pix_out (pix_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_out <= '0;
         win_out  <= 1'b0;
         win_oe   <= 1'b0;
      end else begin
         gain_out <= gain_d;
         win_out  <= pin_win && (mode == bwr_pkg::BWR_DRIVE);
         win_oe   <= (mode == bwr_pkg::BWR_DRIVE);
      end
   end

endmodule

// File: rtl/bwr_checker.sv
module bwr_checker #(
   parameter int PIX_W    = 10,
   parameter int FRAC_W   = 8,
   parameter int RAMP_LEN = 4,
   parameter int GAIN_W   = FRAC_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_gate,
   input logic              win_ext_in,
   input logic [PIX_W-1:0]  pix_in,
   input logic              win_out,
   input logic [GAIN_W-1:0] gain_out,
   input logic [PIX_W-1:0]  pix_out
);

   localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << FRAC_W);
   localparam logic [GAIN_W-1:0] STEP  = GAIN_W'((1 << FRAC_W) / RAMP_LEN);

   assert_gain_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gain_out <= UNITY);

   assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((gain_out >= $past(gain_out)) ? (gain_out - $past(gain_out))
                                     : ($past(gain_out) - gain_out)) <= STEP);

   assert_rise_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(mode_gate) && (gain_out > $past(gain_out))) |-> win_out);

   assert_force_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_gate) && !$past(win_ext_in)) |-> (gain_out <= $past(gain_out)));

   assert_zero_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_out == '0) |-> (pix_out == '0));

   assert_unity_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_out == UNITY) |-> (pix_out == $past(pix_in)));

endmodule

bind blank_window_ramp bwr_checker #(
   .PIX_W    (PIX_W),
   .FRAC_W   (FRAC_W),
   .RAMP_LEN (RAMP_LEN),
   .GAIN_W   (GAIN_W)
) u_bwr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_gate  (mode_gate),
   .win_ext_in (win_ext_in),
   .pix_in     (pix_in),
   .win_out    (win_out),
   .gain_out   (gain_out),
   .pix_out    (pix_out)
);

// File: tb/tb_blank_window_ramp.sv
`timescale 1ns/1ps
module tb_blank_window_ramp;

   localparam int CNT_W = 11;
   localparam int PIX_W = 10;
   localparam int FRAC_W = 8;
   localparam int RL = 4;
   localparam int STEP = (1 << FRAC_W) / RL;
   localparam int MAXP = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_start = 1'b0;
   logic mode_gate = 1'b0;
   logic [CNT_W-1:0] start_pos = '0;
   logic [CNT_W-1:0] end_pos = '0;
   logic win_ext_in = 1'b1;
   logic [PIX_W-1:0] pix_in = '0;
   logic win_out, win_oe;
   logic [FRAC_W:0] gain_out;
   logic [PIX_W-1:0] pix_out;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // model state
   int m_cnt = MAXP;
   int m_lvl = 0;

   always #2 clk = ~clk;

   blank_window_ramp dut (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .mode_gate(mode_gate),
      .start_pos(start_pos), .end_pos(end_pos), .win_ext_in(win_ext_in),
      .pix_in(pix_in), .win_out(win_out), .win_oe(win_oe),
      .gain_out(gain_out), .pix_out(pix_out)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // One pixel: drive at negedge, update model, sample 1 ns after the edge.
   task automatic step(input bit ls, input int px, input bit ext, input string greq);
      int pos;
      bit pin, tgt;
      int g;
      @(negedge clk);
      line_start = ls;
      pix_in = PIX_W'(px);
      win_ext_in = ext;
      if (ls) pos = 0;
      else if (m_cnt < MAXP) pos = m_cnt + 1;
      else pos = MAXP;
      m_cnt = pos;
      pin = (pos >= int'(start_pos)) && (pos < int'(end_pos));
      tgt = pin && (pos + RL - 1 < int'(end_pos)) && (mode_gate ? ext : 1'b1);
      if (tgt && m_lvl < RL) m_lvl++;
      else if (!tgt && m_lvl > 0) m_lvl--;
      g = m_lvl * STEP;
      @(posedge clk);
      #1;
      check(greq, "gain_out", int'(gain_out), g);
      check("R8", "pix_out", int'(pix_out), (px * g) >> FRAC_W);
      check(mode_gate ? "R6" : "R2", "win_out", int'(win_out), (!mode_gate && pin) ? 1 : 0);
      check(mode_gate ? "R6" : "R2", "win_oe", int'(win_oe), mode_gate ? 0 : 1);
   endtask

   // Point check of the gain on a known pixel, after the step that produced it.
   task automatic expect_gain(input string req, input int exp);
      check(req, "ramp point gain", int'(gain_out), exp);
   endtask

   task automatic run_line(input int len, input bit ext, input string greq);
      for (int i = 0; i < len; i++)
         step(i == 0, (i * 37 + 5) % (1 << PIX_W), ext, greq);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1", "gain_out in reset", int'(gain_out), 0);
      check("R1", "pix_out in reset", int'(pix_out), 0);
      check("R1", "win_out in reset", int'(win_out), 0);
      check("R1", "win_oe in reset", int'(win_oe), 0);
      @(negedge clk);
      rst_n = 1'b1;
      m_cnt = MAXP;
      m_lvl = 0;

      // R1: before any line start the counter sits at 2047, so no window opens
      start_pos = 0; end_pos = 11'd2047;
      for (int i = 0; i < 6; i++) step(1'b0, 100 + i, 1'b1, "R1");

      // R2/R5: drive mode, long window, with point checks on the ramp shape
      start_pos = 10; end_pos = 40;
      for (int i = 0; i < 50; i++) begin
         step(i == 0, (i * 53 + 7) % 1024, 1'b1, "R5");
         if (i == 10) expect_gain("R5", 64);
         if (i == 13) expect_gain("R5", 256);
         if (i == 37) expect_gain("R5", 192);
         if (i == 39) expect_gain("R5", 64);
         if (i == 40) expect_gain("R5", 0);
      end

      // R4: short windows that never reach unity
      start_pos = 5; end_pos = 9;   run_line(16, 1'b1, "R4");
      start_pos = 0; end_pos = 7;   run_line(12, 1'b1, "R4");
      start_pos = 3; end_pos = 3;   run_line(8, 1'b1, "R4");

      // R3: full-scale pixels so that the scaled output spans every gain level
      start_pos = 2; end_pos = 20;
      for (int i = 0; i < 24; i++) step(i == 0, 1023, 1'b1, "R3");

      // R6: gate mode with the external level high follows the internal window
      mode_gate = 1'b1;
      start_pos = 10; end_pos = 40; run_line(50, 1'b1, "R6");
      // R6: external level low for the whole line keeps the output blanked
      run_line(50, 1'b0, "R6");

      // R7: external level falls mid-ramp (pixel 12) and returns (pixel 15)
      for (int i = 0; i < 45; i++) begin
         step(i == 0, 600, !(i >= 12 && i < 15), "R7");
         if (i == 11) expect_gain("R7", 128);
         if (i == 12) expect_gain("R7", 64);
         if (i == 14) expect_gain("R7", 0);
         if (i == 15) expect_gain("R7", 64);
      end
      // R7: pulses during a full window and during the down-ramp
      for (int i = 0; i < 45; i++)
         step(i == 0, i * 20, !((i % 7) == 3), "R7");

      // R10: mid-line restart while the window is open, then in drive mode
      mode_gate = 1'b0;
      start_pos = 4; end_pos = 30;
      for (int i = 0; i < 20; i++) step(i == 0, 512, 1'b1, "R10");
      for (int i = 0; i < 36; i++) step(i == 0, 512, 1'b1, "R10");

      // R9: a long line; the counter saturates at 2047
      start_pos = 11'd2040; end_pos = 11'd2047;
      for (int i = 0; i < 2100; i++) step(i == 0, i % 1024, 1'b1, "R9");

      // R2/R6: exhaustive sweep of small start/end pairs in both modes
      for (int md = 0; md < 2; md++) begin
         mode_gate = md[0];
         for (int s = 0; s < 6; s++)
            for (int e = 0; e < 14; e += 3) begin
               start_pos = CNT_W'(s); end_pos = CNT_W'(e);
               for (int i = 0; i < 18; i++)
                  step(i == 0, (i * 71) % 1024, (i % 5) != 2, md ? "R6" : "R2");
            end
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule